// File: doc/BRIEF.md
# Transmit Source Hold/Release Controller

This block sits inside the link layer of a serial bus controller and gives host software command-level control over the transmit sources. There are eight source codes. Five codes are packet queues, one code is the autoresponse path, and two codes are reserved. The host writes a control word that carries a source selector and three command bits: abort, hold and release. The selected source receives a one-cycle command pulse. Each source keeps a persistent held state that its transmit engine can test before it sends.

Each source's transmit engine marks the start of a request with a one-cycle strobe. The block then records the destination ID and the 48-bit destination offset of that request in the source's own slot. The host reads these values back through two status words, and the same selector that steers the commands also steers the status. The block also keeps a retry flag for the autoresponse path, which follows the acknowledge events. It keeps a sticky error flag that is set when the first data queue is aborted. A bus reset clears all state.

Top module: `txq_ctrl_top`

## Requirements
- R1: The selector is control word bits 26:24. Codes 0–4 are the packet queues, code 6 is the autoresponse path, and codes 5 and 7 are reserved. After a write, ctrl_rdata bits 26:24 return the selector, and bits 27, 31, 23 and 21:0 read 0.
- R2: A write with bit 28 set produces a one-cycle abort_pulse on the selected source in the cycle after the write, and ctrl_rdata bit 28 reads 1 during that cycle. From the next cycle, bit 28 reads 0 and that source's held bit is 0.
- R3: An abort of source 0 sets dt_err, and dt_err stays 1 until a bus reset.
- R4: A write with bit 29 set (and bit 30 clear) sets the held bit of the selected source one cycle after the pulse cycle. The held bits of all other sources keep their values, and bit 29 then reads 0 again.
- R5: A write with bit 30 set (and bit 29 clear) produces a one-cycle release_pulse on the selected source and clears its held bit. Bit 30 then reads 0 again.
- R6: A write with both bit 29 and bit 30 set acts as an abort. The block produces an abort_pulse and no release_pulse, and the held bit ends at 0.
- R7: ar_retry (also on ctrl_rdata bit 22) becomes 1 on the edge after ack_busy. It becomes 0 on the edge after ack_other or retry_timeout, and a clearing event wins over ack_busy in the same cycle.
- R8: A start_stb bit latches start_dest_id and start_offset into that source's slot. While that source is selected, stat_word1 = {offset[47:32], dest_id} and stat_word2 = offset[31:0].
- R9: Commands that select code 5 or 7 produce no pulse and change no held bit. While the selector holds a reserved code, both status words read 0.
- R10: bus_reset clears the selector, the command bits, the held bits, the latched destinations, dt_err and ar_retry on the next edge, and it overrides any write, strobe or acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous bus reset, clears all state |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| start_stb | input | 8 | Per-source request start strobe |
| start_dest_id | input | 16 | Destination ID of the starting request |
| start_offset | input | 48 | Destination offset of the starting request |
| ack_busy | input | 1 | Busy acknowledge on the autoresponse path |
| ack_other | input | 1 | Any other acknowledge on the autoresponse path |
| retry_timeout | input | 1 | Autoresponse retry timeout |
| ctrl_rdata | output | 32 | Control word readback |
| stat_word1 | output | 32 | Selected source's offset high and destination ID |
| stat_word2 | output | 32 | Selected source's offset low |
| held | output | 8 | Per-source held state |
| abort_pulse | output | 8 | Per-source abort command pulse |
| release_pulse | output | 8 | Per-source release command pulse |
| dt_err | output | 1 | Sticky abort flag of source 0 |
| ar_retry | output | 1 | Autoresponse retry flag |

## Verification
The functions that can collide are bus reset and everything else. Bus reset can land in the same cycle as a control write, a start strobe and a busy acknowledge. The bench provokes this by asserting all four in one cycle while other sources are held, dt_err is set and the retry flag is 1. It then judges that every output and both status words read zero on the next edge and that no held bit survives. It also collides a busy acknowledge with a clearing acknowledge, and hold with release, and checks that the clear and the abort win.

// File: rtl/txq_hold_pkg.sv
package txq_hold_pkg;
  localparam int SEL_W     = 3;
  localparam int NSRC      = 1 << SEL_W;
  localparam int ID_W      = 16;
  localparam int OFS_W     = 48;
  localparam int WORD_W    = 32;
  localparam int SEL_LSB   = 24;
  localparam int ABT_BIT   = 28;
  localparam int HLD_BIT   = 29;
  localparam int RLS_BIT   = 30;
  localparam int RETRY_BIT = 22;
  localparam logic [NSRC-1:0] RSVD_MASK = NSRC'(8'b1010_0000);

  typedef struct packed {
    logic abt;
    logic hld;
    logic rls;
  } cmd_t;

  // one-hot target of a selector, zero for reserved codes
  function automatic logic [NSRC-1:0] sel_decode(input logic [SEL_W-1:0] s);
    return (NSRC'(1) << s) & ~RSVD_MASK;
  endfunction

  // resolve the written bits into the effective command
  function automatic cmd_t cmd_resolve(input cmd_t c);
    cmd_t r;
    r.abt = c.abt | (c.hld & c.rls);
    r.hld = c.hld & ~c.rls & ~c.abt;
    r.rls = c.rls & ~c.hld & ~c.abt;
    return r;
  endfunction
endpackage

// File: rtl/txq_ctrl_reg.sv
module txq_ctrl_reg
  import txq_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel_q,
  output cmd_t              cmd_q,
  output cmd_t              cmd_go
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cmd_q <= '0;
    end else if (bus_reset) begin
      sel_q <= '0;
      cmd_q <= '0;
    end else if (wr_en) begin
      sel_q     <= wr_data[SEL_LSB +: SEL_W];
      cmd_q.abt <= wr_data[ABT_BIT];
      cmd_q.hld <= wr_data[HLD_BIT];
      cmd_q.rls <= wr_data[RLS_BIT];
    end else begin
      cmd_q <= '0;
    end
  end

  assign cmd_go = cmd_resolve(cmd_q);

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_q) && !wr_en) |=> (cmd_q == '0)); // R2
endmodule

// File: rtl/txq_src_slot.sv
module txq_src_slot
  import txq_hold_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             do_abort,
  input  logic             do_hold,
  input  logic             do_release,
  input  logic             start_stb,
  input  logic [ID_W-1:0]  start_id,
  input  logic [OFS_W-1:0] start_ofs,
  output logic             held_q,
  output logic [ID_W-1:0]  dest_id_q,
  output logic [OFS_W-1:0] dest_ofs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (bus_reset || do_abort || do_release) begin
      held_q <= 1'b0;
    end else if (do_hold) begin
      held_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_id_q  <= '0;
      dest_ofs_q <= '0;
    end else if (bus_reset) begin
      dest_id_q  <= '0;
      dest_ofs_q <= '0;
    end else if (start_stb) begin
      dest_id_q  <= start_id;
      dest_ofs_q <= start_ofs;
    end
  end

  AST_HOLD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_hold && !bus_reset) |=> held_q); // R4
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_release || do_abort) |=> !held_q); // R5
  AST_DEST_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb && !bus_reset) |=> (dest_id_q == $past(start_id)) && (dest_ofs_q == $past(start_ofs))); // R8
endmodule

// File: rtl/txq_ar_retry.sv
module txq_ar_retry (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic ack_busy,
  input  logic ack_other,
  input  logic retry_timeout,
  output logic ar_retry
);
  logic clr_evt;
  assign clr_evt = bus_reset | ack_other | retry_timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ar_retry <= 1'b0;
    else if (clr_evt)  ar_retry <= 1'b0;
    else if (ack_busy) ar_retry <= 1'b1;
  end

  AST_RETRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_busy && !ack_other && !retry_timeout && !bus_reset) |=> ar_retry); // R7
  AST_RETRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_other || retry_timeout) |=> !ar_retry); // R7
endmodule

// File: rtl/txq_ctrl_top.sv
module txq_ctrl_top
  import txq_hold_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_reset,
  input  logic                   wr_en,
  input  logic [WORD_W-1:0]      wr_data,
  input  logic [NSRC-1:0]        start_stb,
  input  logic [ID_W-1:0]        start_dest_id,
  input  logic [OFS_W-1:0]       start_offset,
  input  logic                   ack_busy,
  input  logic                   ack_other,
  input  logic                   retry_timeout,
  output logic [WORD_W-1:0]      ctrl_rdata,
  output logic [WORD_W-1:0]      stat_word1,
  output logic [WORD_W-1:0]      stat_word2,
  output logic [NSRC-1:0]        held,
  output logic [NSRC-1:0]        abort_pulse,
  output logic [NSRC-1:0]        release_pulse,
  output logic                   dt_err,
  output logic                   ar_retry
);
  logic [SEL_W-1:0] sel_q;
  cmd_t             cmd_q;
  cmd_t             cmd_go;
  logic [NSRC-1:0]  tgt_vec;
  logic [NSRC-1:0]  hold_vec;
  logic [NSRC-1:0]  stb_vec;
  logic [ID_W-1:0]  id_arr  [NSRC];
  logic [OFS_W-1:0] ofs_arr [NSRC];
  logic [ID_W-1:0]  sel_id;
  logic [OFS_W-1:0] sel_ofs;
  logic             sel_ok;

  txq_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .wr_en(wr_en), .wr_data(wr_data),
    .sel_q(sel_q), .cmd_q(cmd_q), .cmd_go(cmd_go)
  );

  assign tgt_vec       = sel_decode(sel_q);
  assign sel_ok        = |tgt_vec;
  assign abort_pulse   = cmd_go.abt ? tgt_vec : '0;
  assign release_pulse = cmd_go.rls ? tgt_vec : '0;
  assign hold_vec      = cmd_go.hld ? tgt_vec : '0;
  assign stb_vec       = start_stb & ~RSVD_MASK;

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    txq_src_slot u_slot (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
      .do_abort(abort_pulse[i]), .do_hold(hold_vec[i]), .do_release(release_pulse[i]),
      .start_stb(stb_vec[i]), .start_id(start_dest_id), .start_ofs(start_offset),
      .held_q(held[i]), .dest_id_q(id_arr[i]), .dest_ofs_q(ofs_arr[i])
    );
  end

  always_comb begin
    sel_id  = '0;
    sel_ofs = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (tgt_vec[i]) begin
        sel_id  = id_arr[i];
        sel_ofs = ofs_arr[i];
      end
    end
  end

  assign stat_word1 = {sel_ofs[OFS_W-1 -: 16], sel_id};
  assign stat_word2 = sel_ofs[31:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dt_err <= 1'b0;
    else if (bus_reset)      dt_err <= 1'b0;
    else if (abort_pulse[0]) dt_err <= 1'b1;
  end

  txq_ar_retry u_retry (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .ack_busy(ack_busy), .ack_other(ack_other), .retry_timeout(retry_timeout),
    .ar_retry(ar_retry)
  );

  always_comb begin
    ctrl_rdata = '0;
    ctrl_rdata[SEL_LSB +: SEL_W] = sel_q;
    ctrl_rdata[ABT_BIT]   = cmd_q.abt;
    ctrl_rdata[HLD_BIT]   = cmd_q.hld;
    ctrl_rdata[RLS_BIT]   = cmd_q.rls;
    ctrl_rdata[RETRY_BIT] = ar_retry;
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({abort_pulse, hold_vec, release_pulse})); // R6
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> (stat_word1 == '0) && (stat_word2 == '0) && (abort_pulse == '0) && (release_pulse == '0)); // R9
  AST_DTERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_err && !bus_reset) |=> dt_err); // R3
  AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (held == '0) && (ctrl_rdata == '0) && !dt_err); // R10
endmodule

// File: tb/test_txq_ctrl_top.sv
module test_txq_ctrl_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  start_stb = '0;
  logic [15:0] start_dest_id = '0;
  logic [47:0] start_offset = '0;
  logic        ack_busy = 1'b0, ack_other = 1'b0, retry_timeout = 1'b0;
  logic [31:0] ctrl_rdata, stat_word1, stat_word2;
  logic [7:0]  held, abort_pulse, release_pulse;
  logic        dt_err, ar_retry;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] held_m = '0;
  logic       dterr_m = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  txq_ctrl_top i_txq_ctrl_top (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .wr_en(wr_en), .wr_data(wr_data),
    .start_stb(start_stb), .start_dest_id(start_dest_id), .start_offset(start_offset),
    .ack_busy(ack_busy), .ack_other(ack_other), .retry_timeout(retry_timeout),
    .ctrl_rdata(ctrl_rdata), .stat_word1(stat_word1), .stat_word2(stat_word2),
    .held(held), .abort_pulse(abort_pulse), .release_pulse(release_pulse),
    .dt_err(dt_err), .ar_retry(ar_retry)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit code_ok(input int c);
    return (c != 5) && (c != 7);
  endfunction

  function automatic logic [15:0] id_of(input int c);
    return 16'hA000 + 16'(c * 16'h0111);
  endfunction

  function automatic logic [47:0] ofs_of(input int c);
    return {16'hB000 + 16'(c), 32'hC0DE_0000 + 32'(c * 32'h1357)};
  endfunction

  // write a command, check the pulse cycle, then the settled cycle
  task automatic cmd(input int c, input bit a, input bit h, input bit r, input string req);
    logic [7:0] tgt, exp_ab, exp_rl;
    bit ea, eh, er;
    ea = a | (h & r);
    eh = h & ~r & ~a;
    er = r & ~h & ~a;
    tgt = code_ok(c) ? (8'd1 << c) : 8'd0;
    exp_ab = ea ? tgt : 8'd0;
    exp_rl = er ? tgt : 8'd0;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = (32'(c) << 24) | (32'(a) << 28) | (32'(h) << 29) | (32'(r) << 30);
    @(negedge clk);
    wr_en = 1'b0;
    chk({req, " abort pulse"}, 64'(abort_pulse), 64'(exp_ab));
    chk({req, " release pulse"}, 64'(release_pulse), 64'(exp_rl));
    chk({req, " R1 readback"}, 64'(ctrl_rdata & 32'h7F00_0000), 64'(wr_data & 32'h7700_0000));
    if (ea || er) held_m = held_m & ~tgt;
    else if (eh) held_m = held_m | tgt;
    if (exp_ab[0]) dterr_m = 1'b1;
    @(negedge clk);
    chk({req, " held"}, 64'(held), 64'(held_m));
    chk({req, " cmd bits self-clear"}, 64'(ctrl_rdata[30:28]), 64'd0);
    chk({req, " R3 dt_err"}, 64'(dt_err), 64'(dterr_m));
  endtask

  task automatic select(input int c);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 32'(c) << 24;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input int c);
    @(negedge clk);
    start_stb = 8'd1 << c;
    start_dest_id = id_of(c);
    start_offset = ofs_of(c);
    @(negedge clk);
    start_stb = '0;
  endtask

  task automatic ack(input bit b, input bit o, input bit t, input bit exp, input string req);
    @(negedge clk);
    ack_busy = b; ack_other = o; retry_timeout = t;
    @(negedge clk);
    ack_busy = 0; ack_other = 0; retry_timeout = 0;
    chk({req, " ar_retry"}, 64'(ar_retry), 64'(exp));
    chk({req, " retry bit 22"}, 64'(ctrl_rdata[22]), 64'(exp));
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset ctrl", 64'(ctrl_rdata), 64'd0);
    chk("R10 reset held", 64'(held), 64'd0);
    chk("R10 reset stat1", 64'(stat_word1), 64'd0);

    // R4/R9: hold sweep over every code, other sources keep their state
    for (int c = 0; c < 8; c++) cmd(c, 0, 1, 0, "R4 hold sweep");
    // R8/R9: destination latch and readback per code
    for (int c = 0; c < 8; c++) strobe(c);
    for (int c = 0; c < 8; c++) begin
      select(c);
      chk("R8 R9 stat1", 64'(stat_word1), code_ok(c) ? 64'({ofs_of(c)[47:32], id_of(c)}) : 64'd0);
      chk("R8 R9 stat2", 64'(stat_word2), code_ok(c) ? 64'(ofs_of(c)[31:0]) : 64'd0);
    end
    // R5: release sweep
    for (int c = 0; c < 8; c++) cmd(c, 0, 0, 1, "R5 release sweep");
    // R2/R3: abort of held sources, reverse order so code 0 comes last
    for (int c = 0; c < 8; c++) cmd(c, 0, 1, 0, "R4 rehold");
    for (int c = 7; c >= 0; c--) cmd(c, 1, 0, 0, "R2 abort sweep");
    // R6: hold+release together on held sources
    cmd(2, 0, 1, 0, "R4 hold2");
    cmd(6, 0, 1, 0, "R4 hold6");
    cmd(2, 0, 1, 1, "R6 both");
    cmd(6, 1, 1, 1, "R6 all three");
    cmd(5, 0, 1, 1, "R9 R6 reserved");

    // R7
    ack(1, 0, 0, 1, "R7 busy");
    ack(0, 1, 0, 0, "R7 other ack");
    ack(1, 0, 0, 1, "R7 busy again");
    ack(0, 0, 1, 0, "R7 timeout");
    ack(1, 0, 0, 1, "R7 busy third");
    ack(1, 1, 0, 0, "R7 collide");
    ack(1, 0, 0, 1, "R7 busy fourth");

    // R10: bus reset colliding with write, strobe and busy ack
    cmd(1, 0, 1, 0, "R4 hold1");
    cmd(4, 0, 1, 0, "R4 hold4");
    @(negedge clk);
    bus_reset = 1; wr_en = 1; wr_data = 32'h2300_0000;
    start_stb = 8'h02; start_dest_id = 16'h5555; start_offset = 48'h1234_5678_9ABC;
    ack_busy = 1;
    @(negedge clk);
    bus_reset = 0; wr_en = 0; start_stb = '0; ack_busy = 0;
    held_m = '0; dterr_m = 1'b0;
    chk("R10 held", 64'(held), 64'd0);
    chk("R10 ctrl", 64'(ctrl_rdata), 64'd0);
    chk("R10 dt_err", 64'(dt_err), 64'd0);
    chk("R10 ar_retry", 64'(ar_retry), 64'd0);
    chk("R10 stat1 sel0", 64'(stat_word1), 64'd0);
    select(1);
    chk("R10 stat1 sel1", 64'(stat_word1), 64'd0);
    chk("R10 stat2 sel1", 64'(stat_word2), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule